// File: doc/BRIEF.md
# Partitioned Event Readout Builder

The block builds one output fragment per completed event. An event ID is taken from an upstream completion queue through a valid/ready handshake. The block first writes a fragment header that carries a bitmap of the channels present. It then drains the buffer partition of each present channel in ascending channel order, up to and including that channel's trailer. It closes the fragment with a trailer that holds the fragment word count, a truncation flag and the event ID. Fragment words go into an internal 128-entry output data FIFO. A per-event summary goes into an internal 128-entry length FIFO. A downstream reader drains both FIFOs through show-ahead read ports.

The buffer memory is seen through a simple pop-style read port. Each request names one channel and returns that partition's next word one cycle later. Partitions of absent channels are never touched. When zero suppression is on, a channel whose header is directly followed by its trailer adds nothing to the fragment. A programmable limit caps the number of channel words per event. Words beyond the limit are read and discarded, the trailer is flagged, and a one-cycle interrupt is raised.

Top module: `frag_builder`

## Requirements
- R1: An event is taken only in a cycle where `evt_valid_i` and `evt_ready_o` are both high. `evt_ready_o` is high only while the block is idle and `evt_valid_i` is high. The present bitmap, the zero-suppress enable and the size limit are latched at that moment.
- R2: The first word of every fragment is `{hdr_pat_i, zeros, bitmap}`, with the pattern in bits [31:28] and the latched present bitmap in bits [NUM_CH-1:0].
- R3: The partition of a channel whose present bit is 0 is never read. Present partitions are read one at a time, in ascending channel order, and each one is read up to and including its first word with tag 4'hB in bits [31:28] (channel trailer), and no further.
- R4: Channel words are appended to the fragment unchanged, in the order they are read.
- R5: With zero suppression on, a channel header (tag 4'hA) that is immediately followed by its channel trailer is dropped together with that trailer. With zero suppression off, both words are kept.
- R6: The last word of every fragment is `{trl_pat_i, trunc, count, event_id}` in bits [31:28], [27], [26:16] and [15:0]. Here count is the number of fragment words including the fragment header and this trailer.
- R7: Channel words written to the fragment are counted; words dropped by R5 are not counted. Once this count equals the latched limit, every further channel word of the event is read but discarded, reading still continues through each remaining present partition to its trailer, and trunc is set.
- R8: `rdmax_irq_o` pulses for exactly one cycle on the first discard of an event, and stays low for an event without discards.
- R9: While either FIFO is full the block waits, and no word is lost or duplicated.
- R10: After reset both FIFOs are empty. A read port shows its oldest entry while not empty and pops it on a read strobe.
- R11: Each completed event pushes exactly one length entry, equal to bits [27:0] of its fragment trailer, at the same time as the trailer is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Completion queue holds an event |
| evt_id_i | input | EID_W | Event ID at the head of the completion queue |
| evt_ready_o | output | 1 | Event taken this cycle |
| present_i | input | NUM_CH | Channel-present bitmap |
| zs_en_i | input | 1 | Zero-suppression enable |
| max_words_i | input | CNT_W-1 | Channel-word limit per event |
| hdr_pat_i | input | PAT_W | Upper bits of the fragment header |
| trl_pat_i | input | PAT_W | Upper bits of the fragment trailer |
| mem_rd_o | output | 1 | Pop the next word of a partition |
| mem_ch_o | output | $clog2(NUM_CH) | Partition to pop |
| mem_data_i | input | DW | Popped word, valid one cycle after the request |
| dout_rd_i | input | 1 | Pop the output data FIFO |
| dout_o | output | DW | Head of the output data FIFO |
| dout_empty_o | output | 1 | Output data FIFO empty |
| len_rd_i | input | 1 | Pop the length FIFO |
| len_o | output | 1+CNT_W+EID_W | Head of the length FIFO |
| len_empty_o | output | 1 | Length FIFO empty |
| rdmax_irq_o | output | 1 | Size limit reached in this event |

## Verification
The bench builds the block with six channels and leaves every other parameter at its default. Six channels keep random present bitmaps dense in both all-absent and all-present patterns, and keep events short enough to run many of them. The full 128-entry FIFO depth is kept, so a single long event with the reader held off drives the data FIFO to full and exercises the wait of R9. Small random size limits, down to zero, make truncation happen in the middle of a channel and across later channels. Channels with no hits are common, so zero suppression is exercised in both settings.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int TAG_W = 4;
  localparam logic [TAG_W-1:0] CH_HDR_TAG = 4'hA;
  localparam logic [TAG_W-1:0] CH_TRL_TAG = 4'hB;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_SEL, S_REQ, S_CAP, S_PROC, S_TRL
  } seq_state_e;
endpackage

// File: rtl/frag_fifo.sv
module frag_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic do_wr, do_rd;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_wr   = wr_i & ~full_o;
  assign do_rd   = rd_i & ~empty_o;
  assign rdata_o = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/frag_seq.sv
module frag_seq
  import frag_pkg::*;
#(
  parameter int NUM_CH = 18,
  parameter int EID_W  = 16,
  parameter int CNT_W  = 11,
  parameter int PAT_W  = 4,
  parameter int DW     = PAT_W + 1 + CNT_W + EID_W,
  parameter int LW     = 1 + CNT_W + EID_W,
  parameter int MCH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [EID_W-1:0]  evt_id_i,
  output logic              evt_ready_o,
  input  logic [NUM_CH-1:0] present_i,
  input  logic              zs_en_i,
  input  logic [CNT_W-2:0]  max_words_i,
  input  logic [PAT_W-1:0]  hdr_pat_i,
  input  logic [PAT_W-1:0]  trl_pat_i,
  output logic              mem_rd_o,
  output logic [MCH_W-1:0]  mem_ch_o,
  input  logic [DW-1:0]     mem_data_i,
  output logic              dwr_o,
  output logic [DW-1:0]     dwdata_o,
  input  logic              dfull_i,
  output logic              lwr_o,
  output logic [LW-1:0]     lwdata_o,
  input  logic              lfull_i,
  output logic              rdmax_irq_o,
  output logic [NUM_CH-1:0] present_o
);
  localparam int CH_W = $clog2(NUM_CH + 1);
  localparam int MW   = CNT_W - 1;
  localparam int PADW = DW - PAT_W - NUM_CH;

  seq_state_e state_q, state_d;
  logic [EID_W-1:0]  eid_q, eid_d;
  logic [NUM_CH-1:0] pres_q, pres_d;
  logic              zs_q, zs_d;
  logic [MW-1:0]     max_q, max_d, dcnt_q, dcnt_d;
  logic [CNT_W-1:0]  fcnt_q, fcnt_d, fcnt_tot;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [DW-1:0]     cur_q, cur_d, hold_q, hold_d;
  logic              pend_q, pend_d, trunc_q, trunc_d;
  logic              cur_hdr, cur_trl, room, adv;

  assign cur_hdr   = (cur_q[DW-1 -: TAG_W] == CH_HDR_TAG);
  assign cur_trl   = (cur_q[DW-1 -: TAG_W] == CH_TRL_TAG);
  assign room      = (dcnt_q < max_q);
  assign fcnt_tot  = fcnt_q + CNT_W'(1);
  assign mem_ch_o  = ch_q[MCH_W-1:0];
  assign present_o = pres_q;

  always_comb begin
    state_d = state_q; eid_d = eid_q; pres_d = pres_q; zs_d = zs_q;
    max_d = max_q; dcnt_d = dcnt_q; fcnt_d = fcnt_q; ch_d = ch_q;
    cur_d = cur_q; hold_d = hold_q; pend_d = pend_q; trunc_d = trunc_q;
    evt_ready_o = 1'b0; mem_rd_o = 1'b0; rdmax_irq_o = 1'b0;
    dwr_o = 1'b0; dwdata_o = '0; lwr_o = 1'b0; lwdata_o = '0; adv = 1'b0;
    case (state_q)
      S_IDLE: if (evt_valid_i) begin
        evt_ready_o = 1'b1;
        eid_d = evt_id_i; pres_d = present_i; zs_d = zs_en_i; max_d = max_words_i;
        dcnt_d = '0; fcnt_d = '0; ch_d = '0; pend_d = 1'b0; trunc_d = 1'b0;
        state_d = S_HDR;
      end
      S_HDR: if (!dfull_i) begin
        dwr_o = 1'b1;
        dwdata_o = {hdr_pat_i, {PADW{1'b0}}, pres_q};
        fcnt_d = CNT_W'(1);
        state_d = S_SEL;
      end
      S_SEL: begin
        if (ch_q == CH_W'(NUM_CH))          state_d = S_TRL;
        else if (pres_q[ch_q[MCH_W-1:0]])   state_d = S_REQ;
        else                                ch_d = ch_q + 1'b1;
      end
      S_REQ: begin
        mem_rd_o = 1'b1;
        state_d = S_CAP;
      end
      S_CAP: begin
        cur_d = mem_data_i;
        state_d = S_PROC;
      end
      S_PROC: begin
        if (pend_q && cur_trl) begin
          // empty channel: drop held header and this trailer
          pend_d = 1'b0; ch_d = ch_q + 1'b1; state_d = S_SEL;
        end else if (pend_q) begin
          // flush held header; cur_q is handled next cycle
          if (!room) begin
            pend_d = 1'b0; trunc_d = 1'b1; rdmax_irq_o = ~trunc_q;
          end else if (!dfull_i) begin
            dwr_o = 1'b1; dwdata_o = hold_q; pend_d = 1'b0;
            dcnt_d = dcnt_q + 1'b1; fcnt_d = fcnt_q + 1'b1;
          end
        end else if (zs_q && cur_hdr) begin
          pend_d = 1'b1; hold_d = cur_q; state_d = S_REQ;
        end else begin
          if (!room) begin
            trunc_d = 1'b1; rdmax_irq_o = ~trunc_q; adv = 1'b1;
          end else if (!dfull_i) begin
            dwr_o = 1'b1; dwdata_o = cur_q; adv = 1'b1;
            dcnt_d = dcnt_q + 1'b1; fcnt_d = fcnt_q + 1'b1;
          end
          if (adv) begin
            if (cur_trl) begin ch_d = ch_q + 1'b1; state_d = S_SEL; end
            else state_d = S_REQ;
          end
        end
      end
      S_TRL: if (!dfull_i && !lfull_i) begin
        dwr_o = 1'b1; dwdata_o = {trl_pat_i, trunc_q, fcnt_tot, eid_q};
        lwr_o = 1'b1; lwdata_o = {trunc_q, fcnt_tot, eid_q};
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; eid_q <= '0; pres_q <= '0; zs_q <= 1'b0;
      max_q <= '0; dcnt_q <= '0; fcnt_q <= '0; ch_q <= '0;
      cur_q <= '0; hold_q <= '0; pend_q <= 1'b0; trunc_q <= 1'b0;
    end else begin
      state_q <= state_d; eid_q <= eid_d; pres_q <= pres_d; zs_q <= zs_d;
      max_q <= max_d; dcnt_q <= dcnt_d; fcnt_q <= fcnt_d; ch_q <= ch_d;
      cur_q <= cur_d; hold_q <= hold_d; pend_q <= pend_d; trunc_q <= trunc_d;
    end
  end
endmodule

// File: rtl/frag_builder.sv
module frag_builder #(
  parameter int NUM_CH     = 18,
  parameter int EID_W      = 16,
  parameter int CNT_W      = 11,
  parameter int PAT_W      = 4,
  parameter int DATA_DEPTH = 128,
  parameter int LEN_DEPTH  = 128,
  localparam int DW    = PAT_W + 1 + CNT_W + EID_W,
  localparam int LW    = 1 + CNT_W + EID_W,
  localparam int MCH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [EID_W-1:0]  evt_id_i,
  output logic              evt_ready_o,
  input  logic [NUM_CH-1:0] present_i,
  input  logic              zs_en_i,
  input  logic [CNT_W-2:0]  max_words_i,
  input  logic [PAT_W-1:0]  hdr_pat_i,
  input  logic [PAT_W-1:0]  trl_pat_i,
  output logic              mem_rd_o,
  output logic [MCH_W-1:0]  mem_ch_o,
  input  logic [DW-1:0]     mem_data_i,
  input  logic              dout_rd_i,
  output logic [DW-1:0]     dout_o,
  output logic              dout_empty_o,
  input  logic              len_rd_i,
  output logic [LW-1:0]     len_o,
  output logic              len_empty_o,
  output logic              rdmax_irq_o
);
  logic              dwr, dfull, lwr, lfull;
  logic [DW-1:0]     dwdata;
  logic [LW-1:0]     lwdata;
  logic [NUM_CH-1:0] ev_present;

  frag_seq #(
    .NUM_CH(NUM_CH), .EID_W(EID_W), .CNT_W(CNT_W), .PAT_W(PAT_W),
    .DW(DW), .LW(LW), .MCH_W(MCH_W)
  ) u_seq (
    .clk_i, .rst_ni, .evt_valid_i, .evt_id_i, .evt_ready_o,
    .present_i, .zs_en_i, .max_words_i, .hdr_pat_i, .trl_pat_i,
    .mem_rd_o, .mem_ch_o, .mem_data_i,
    .dwr_o(dwr), .dwdata_o(dwdata), .dfull_i(dfull),
    .lwr_o(lwr), .lwdata_o(lwdata), .lfull_i(lfull),
    .rdmax_irq_o, .present_o(ev_present)
  );

  frag_fifo #(.W(DW), .DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk_i, .rst_ni, .wr_i(dwr), .wdata_i(dwdata), .full_o(dfull),
    .rd_i(dout_rd_i), .rdata_o(dout_o), .empty_o(dout_empty_o)
  );

  frag_fifo #(.W(LW), .DEPTH(LEN_DEPTH)) u_len_fifo (
    .clk_i, .rst_ni, .wr_i(lwr), .wdata_i(lwdata), .full_o(lfull),
    .rd_i(len_rd_i), .rdata_o(len_o), .empty_o(len_empty_o)
  );
endmodule

// File: rtl/frag_builder_chk.sv
module frag_builder_chk #(
  parameter int NUM_CH = 18,
  parameter int DW     = 32,
  parameter int LW     = 28,
  parameter int MCH_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic              evt_ready_o,
  input logic              mem_rd_o,
  input logic [MCH_W-1:0]  mem_ch_o,
  input logic [NUM_CH-1:0] present,
  input logic              dwr,
  input logic              dfull,
  input logic [DW-1:0]     dwdata,
  input logic              lwr,
  input logic              lfull,
  input logic [LW-1:0]     lwdata,
  input logic              rdmax_irq_o
);
  AST_READY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_ready_o |-> evt_valid_i); // R1
  AST_NO_ABSENT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (32'(mem_ch_o) < NUM_CH) && present[mem_ch_o]); // R3
  AST_ONE_READ_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o); // R3
  AST_NO_DATA_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwr |-> !dfull); // R9
  AST_NO_LEN_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lwr |-> !lfull); // R9
  AST_LEN_WITH_TRAILER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lwr |-> dwr && (dwdata[LW-1:0] == lwdata)); // R11
  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdmax_irq_o |=> !rdmax_irq_o); // R8
endmodule

bind frag_builder frag_builder_chk #(
  .NUM_CH(NUM_CH), .DW(DW), .LW(LW), .MCH_W(MCH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i), .evt_ready_o(evt_ready_o),
  .mem_rd_o(mem_rd_o), .mem_ch_o(mem_ch_o), .present(ev_present),
  .dwr(dwr), .dfull(dfull), .dwdata(dwdata),
  .lwr(lwr), .lfull(lfull), .lwdata(lwdata), .rdmax_irq_o(rdmax_irq_o)
);

// File: tb/frag_builder_test.sv
`timescale 1ns/1ps
module frag_builder_test;
  localparam int NCH  = 6;
  localparam int PMAX = 512;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        evt_valid = 0;
  logic [15:0] evt_id = 0;
  logic        evt_ready;
  logic [NCH-1:0] present = 0;
  logic        zs_en = 0;
  logic [9:0]  max_words = 10'd1023;
  logic [3:0]  hdr_pat = 4'hE, trl_pat = 4'hD;
  logic        mem_rd;
  logic [2:0]  mem_ch;
  logic [31:0] mem_data = 0;
  logic        dout_rd = 0, len_rd = 0;
  logic [31:0] dout;
  logic [27:0] len;
  logic        dout_empty, len_empty, irq;

  frag_builder #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_id_i(evt_id),
    .evt_ready_o(evt_ready), .present_i(present), .zs_en_i(zs_en),
    .max_words_i(max_words), .hdr_pat_i(hdr_pat), .trl_pat_i(trl_pat),
    .mem_rd_o(mem_rd), .mem_ch_o(mem_ch), .mem_data_i(mem_data),
    .dout_rd_i(dout_rd), .dout_o(dout), .dout_empty_o(dout_empty),
    .len_rd_i(len_rd), .len_o(len), .len_empty_o(len_empty), .rdmax_irq_o(irq)
  );

  int checks = 0, failures = 0;
  logic [31:0] part [NCH][PMAX];
  int ptr [NCH];
  logic ptr_clr = 0;
  int irq_cnt = 0, bad_reads = 0;

  // partition model: pop with one-cycle latency
  always @(posedge clk) begin
    if (ptr_clr) begin
      for (int c = 0; c < NCH; c++) ptr[c] <= 0;
    end else if (mem_rd && int'(mem_ch) < NCH && ptr[mem_ch] < PMAX) begin
      mem_data <= part[mem_ch][ptr[mem_ch]];
      ptr[mem_ch] <= ptr[mem_ch] + 1;
    end
  end

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (mem_rd && (int'(mem_ch) >= NCH || !present[mem_ch])) bad_reads++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hit_w();
    return {4'($urandom_range(0, 9)), 28'($urandom)};
  endfunction

  task automatic fill_ch(input int c, input int nhits, input bit pres);
    int i = 0;
    part[c][i++] = {4'hA, 28'($urandom)};
    for (int k = 0; k < nhits; k++) part[c][i++] = hit_w();
    if (pres) part[c][i++] = {4'hB, 28'($urandom)};
    else part[c][i++] = hit_w();
    while (i < PMAX) part[c][i++] = hit_w();
  endtask

  logic [31:0] exp_q[$];
  int exp_end [NCH];
  bit exp_trunc;

  task automatic build_exp(input logic [15:0] eid);
    int dw = 0;
    exp_q.delete();
    exp_trunc = 0;
    exp_q.push_back({hdr_pat, 22'd0, present});
    for (int c = 0; c < NCH; c++) begin
      exp_end[c] = 0;
      if (present[c]) begin
        int i = 0;
        forever begin
          logic [31:0] w = part[c][i];
          if (zs_en && w[31:28] == 4'hA && part[c][i+1][31:28] == 4'hB) begin
            i += 2; break;
          end
          if (dw < int'(max_words)) begin exp_q.push_back(w); dw++; end
          else exp_trunc = 1;
          i++;
          if (w[31:28] == 4'hB) break;
        end
        exp_end[c] = i;
      end
    end
    exp_q.push_back({trl_pat, exp_trunc, 11'(exp_q.size() + 1), eid});
  endtask

  task automatic run_event(input logic [15:0] eid, input bit stall);
    int irq0, bad0, n;
    @(negedge clk) ptr_clr = 1;
    @(negedge clk) ptr_clr = 0;
    build_exp(eid);
    irq0 = irq_cnt; bad0 = bad_reads;
    evt_id = eid; evt_valid = 1;
    #0.5;
    chk(evt_ready == 1'b1, "R1 ready with valid in idle", 32'(evt_ready), 32'd1);
    @(negedge clk) evt_valid = 0;
    if (stall) begin
      repeat (1500) @(negedge clk);
      chk(len_empty == 1'b1, "R9 stalled while data FIFO full", 32'(len_empty), 32'd1);
    end
    n = exp_q.size();
    for (int i = 0; i < n; i++) begin
      while (dout_empty) @(negedge clk);
      if (i == 0)          chk(dout == exp_q[i], "R2 fragment header", dout, exp_q[i]);
      else if (i == n - 1) chk(dout == exp_q[i], "R6 R7 fragment trailer", dout, exp_q[i]);
      else                 chk(dout == exp_q[i], "R4 R5 channel word", dout, exp_q[i]);
      dout_rd = 1;
      @(negedge clk) dout_rd = 0;
    end
    while (len_empty) @(negedge clk);
    chk(len == exp_q[n-1][27:0], "R11 length entry", 32'(len), 32'(exp_q[n-1][27:0]));
    len_rd = 1;
    @(negedge clk) len_rd = 0;
    repeat (3) @(negedge clk);
    chk(len_empty && dout_empty, "R11 R9 nothing extra", {30'd0, len_empty, dout_empty}, 32'd3);
    chk(irq_cnt - irq0 == int'(exp_trunc), "R8 irq pulses", 32'(irq_cnt - irq0), 32'(exp_trunc));
    chk(bad_reads == bad0, "R3 no absent reads", 32'(bad_reads - bad0), 32'd0);
    for (int c = 0; c < NCH; c++)
      if (present[c]) chk(ptr[c] == exp_end[c], "R3 R7 read up to trailer", 32'(ptr[c]), 32'(exp_end[c]));
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NCH; c++) ptr[c] = 0;
    repeat (3) @(negedge clk);
    chk(dout_empty && len_empty, "R10 empty after reset", {30'd0, dout_empty, len_empty}, 32'd3);
    chk(evt_ready == 0, "R1 no ready without valid", 32'(evt_ready), 32'd0);
    chk(irq == 0, "R8 irq low at reset", 32'(irq), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(evt_ready == 0, "R1 idle without valid", 32'(evt_ready), 32'd0);

    // all channels absent: header + trailer only
    present = '0;
    for (int c = 0; c < NCH; c++) fill_ch(c, 3, 0);
    run_event(16'h0100, 0);

    // empty channels with and without zero suppression (R5)
    present = 6'b101101;
    for (int c = 0; c < NCH; c++) fill_ch(c, (c == 2) ? 4 : 0, present[c]);
    zs_en = 0; run_event(16'h0101, 0);
    zs_en = 1; run_event(16'h0102, 0);

    // size limit hit inside a channel (R7)
    present = 6'b111111; zs_en = 0; max_words = 10'd5;
    for (int c = 0; c < NCH; c++) fill_ch(c, 3, 1);
    run_event(16'h0103, 0);
    max_words = 10'd0; run_event(16'h0104, 0);
    // limit exactly met: no truncation
    max_words = 10'd30; run_event(16'h0105, 0);

    // long event with reader held off (R9)
    present = 6'b010010; max_words = 10'd1023; zs_en = 1;
    for (int c = 0; c < NCH; c++) fill_ch(c, 150, present[c]);
    run_event(16'hBEEF, 1);

    // random events
    for (int e = 0; e < 40; e++) begin
      for (int c = 0; c < NCH; c++) begin
        present[c] = ($urandom_range(0, 9) < 7);
        fill_ch(c, ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 6), present[c]);
      end
      zs_en = $urandom_range(0, 1);
      max_words = ($urandom_range(0, 2) == 0) ? 10'($urandom_range(0, 12)) : 10'd1023;
      hdr_pat = 4'($urandom); trl_pat = 4'($urandom);
      run_event(16'($urandom), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule